// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of eight pins, controlled from a simple memory-mapped register bus. Each pin is governed by a direction bit and an output-latch bit, and the port offers a third address whose read returns the synchronized pad levels. The output-latch bit has two jobs. On an output pin it sets the driven level. On an input pin it turns on the pull-up. Writing ones to the pin-level address inverts the matching output-latch bits, whatever the pin direction, so software can flip a pin with a single write.

Pad levels enter through a two-stage synchronizer before they can be read. A sleep input freezes the synchronizer. The pad side of its first stage is then forced to zero, so a floating pad cannot disturb logic, and both stages hold the levels captured before sleep began. A global pull-up disable input forces every pull-up off.

The synchronizer has two named modes, picked every cycle from the sleep input. SYN_TRACK shifts pad levels through the stages. SYN_FROZEN holds them. Rising sleep moves the synchronizer from SYN_TRACK to SYN_FROZEN, and falling sleep moves it back. The output latch takes one of three named update kinds each cycle: WK_IDLE holds it, WK_LOAD loads the bus data, and WK_TOGGLE inverts the selected bits. The read path selects one of RSEL_NONE, RSEL_DIR, RSEL_OUT or RSEL_PIN.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low, the direction and output-latch registers and both synchronizer stages are cleared at once, with no clock edge needed, so pad_oe and pad_pu are all zero.
- R2: A clock edge with wr_dir_en high loads wr_data into the direction register. pad_oe equals the direction register, and a bit of 1 marks the pin as an output.
- R3: pad_out equals the output-latch register for every pin.
- R4: pad_pu[i] is 1 only when direction bit i is 0, output-latch bit i is 1 and pu_disable is 0. An output pin therefore never has its pull-up on.
- R5: A clock edge with wr_pin_en high and wr_out_en low inverts each output-latch bit where wr_data is 1 and leaves the bits where it is 0 unchanged, for input and output pins alike.
- R6: When wr_out_en and wr_pin_en are both high at the same edge, the output latch loads wr_data and the toggle is ignored.
- R7: rd_data is combinational. With rd_pin_en high it returns the synchronized pin levels. Otherwise, with rd_out_en high it returns the output latch, and otherwise, with rd_dir_en high it returns the direction register. With no strobe high it returns 0.
- R8: With sleep_en low, a change on pad_in appears on the pin-level read after exactly two rising clock edges, and not after one.
- R9: While sleep_en is high, the pin-level read holds the value captured before sleep, whatever pad_in does. After sleep_en falls, pad levels reach the read two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_dir_en | input | 1 | Write strobe for the direction register |
| wr_out_en | input | 1 | Write strobe for the output-latch register |
| wr_pin_en | input | 1 | Write strobe for the pin-level address (toggle) |
| wr_data | input | 8 | Write data shared by all three addresses |
| rd_dir_en | input | 1 | Read strobe for the direction register |
| rd_out_en | input | 1 | Read strobe for the output-latch register |
| rd_pin_en | input | 1 | Read strobe for the synchronized pin levels |
| rd_data | output | 8 | Read data |
| pu_disable | input | 1 | Global pull-up disable |
| sleep_en | input | 1 | Freezes the input synchronizer |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Level driven on each pad |
| pad_oe | output | 8 | Output enable for each pad |
| pad_pu | output | 8 | Pull-up enable for each pad |

## Verification
Register writes take effect on the edge they meet, so pad_out, pad_oe and pad_pu are due one edge after a write. The read path adds no delay of its own. A pad change is due on the pin-level read two edges later, and not at all while sleep is held. The bench applies every input just after a falling edge and advances a model of the registers and of both synchronizer stages at each rising edge. It compares the ports at the next falling edge, which is the first point where each result is settled. Directed steps check the one-edge and two-edge pin-read points explicitly, and they also check reset taking effect between clock edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_LOAD,
        WK_TOGGLE
    } wr_kind_e;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_DIR,
        RSEL_OUT,
        RSEL_PIN
    } rd_sel_e;

    typedef enum logic {
        SYN_TRACK,
        SYN_FROZEN
    } sync_mode_e;

endpackage

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir_en,
    input  logic             wr_out_en,
    input  logic             wr_pin_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q
);

    wr_kind_e         kind;
    logic [WIDTH-1:0] out_next;

    // a direct load outranks a toggle arriving in the same cycle
    always_comb begin
        if (wr_out_en)
            kind = WK_LOAD;
        else if (wr_pin_en)
            kind = WK_TOGGLE;
        else
            kind = WK_IDLE;
    end

    always_comb begin
        unique case (kind)
            WK_LOAD:   out_next = wr_data;
            WK_TOGGLE: out_next = out_q ^ wr_data;
            default:   out_next = out_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_dir_en)
            dir_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_next;
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir_en |=> dir_q == $past(wr_data)); // R2
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pin_en && !wr_out_en) |=> out_q == ($past(out_q) ^ $past(wr_data))); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_out_en && wr_pin_en) |=> out_q == $past(wr_data)); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_out_en && !wr_pin_en) |=> $stable(out_q)); // R5

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_en,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] sync_q
);

    localparam int LAST = STAGES - 1;

    sync_mode_e       mode;
    logic             shift_en;
    logic [WIDTH-1:0] gated_in;
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb mode = sleep_en ? SYN_FROZEN : SYN_TRACK;

    always_comb begin
        unique case (mode)
            SYN_FROZEN: begin
                shift_en = 1'b0;
                gated_in = '0;
            end
            default: begin
                shift_en = 1'b1;
                gated_in = pad_in;
            end
        endcase
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] stage_d;
            if (s == 0) begin : g_head
                assign stage_d = gated_in;
            end else begin : g_tail
                assign stage_d = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (shift_en)
                    stage_q[s] <= stage_d;
            end
        end
    endgenerate

    assign sync_q = stage_q[LAST];

    AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_en |=> stage_q[0] == $past(pad_in)); // R8
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_en |=> $stable(sync_q)); // R9

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             rd_dir_en,
    input  logic             rd_out_en,
    input  logic             rd_pin_en,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] out_q,
    input  logic [WIDTH-1:0] pin_q,
    output logic [WIDTH-1:0] rd_data
);

    rd_sel_e sel;

    always_comb begin
        if (rd_pin_en)
            sel = RSEL_PIN;
        else if (rd_out_en)
            sel = RSEL_OUT;
        else if (rd_dir_en)
            sel = RSEL_DIR;
        else
            sel = RSEL_NONE;
    end

    always_comb begin
        unique case (sel)
            RSEL_PIN: rd_data = pin_q;
            RSEL_OUT: rd_data = out_q;
            RSEL_DIR: rd_data = dir_q;
            default:  rd_data = '0;
        endcase
    end

    always_comb begin
        if (!rd_dir_en && !rd_out_en && !rd_pin_en)
            AST_IDLE_READ_ZERO: assert (rd_data == '0); // R7
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir_en,
    input  logic             wr_out_en,
    input  logic             wr_pin_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_dir_en,
    input  logic             rd_out_en,
    input  logic             rd_pin_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             pu_disable,
    input  logic             sleep_en,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pin_q;

    gpio_pin_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dir_en (wr_dir_en),
        .wr_out_en (wr_out_en),
        .wr_pin_en (wr_pin_en),
        .wr_data   (wr_data),
        .dir_q     (dir_q),
        .out_q     (out_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_en (sleep_en),
        .pad_in   (pad_in),
        .sync_q   (pin_q)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
        .rd_dir_en (rd_dir_en),
        .rd_out_en (rd_out_en),
        .rd_pin_en (rd_pin_en),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .pin_q     (pin_q),
        .rd_data   (rd_data)
    );

    assign pad_oe  = dir_q;
    assign pad_out = out_q;
    assign pad_pu  = ~dir_q & out_q & {WIDTH{~pu_disable}};

    AST_RESET_TRISTATE: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0 && pad_pu == '0)); // R1
    AST_NO_PULLUP_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pu) == '0); // R4
    AST_PUD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pu_disable |-> pad_pu == '0); // R4

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_dir_en = 0, wr_out_en = 0, wr_pin_en = 0;
    logic [W-1:0] wr_data = '0;
    logic         rd_dir_en = 0, rd_out_en = 0, rd_pin_en = 0;
    logic [W-1:0] rd_data;
    logic         pu_disable = 0, sleep_en = 0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_dir = '0, m_out = '0, m_s1 = '0, m_s2 = '0;

    always #10 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n),
        .wr_dir_en(wr_dir_en), .wr_out_en(wr_out_en), .wr_pin_en(wr_pin_en),
        .wr_data(wr_data),
        .rd_dir_en(rd_dir_en), .rd_out_en(rd_out_en), .rd_pin_en(rd_pin_en),
        .rd_data(rd_data),
        .pu_disable(pu_disable), .sleep_en(sleep_en), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_pu();
        return ~m_dir & m_out & {W{~pu_disable}};
    endfunction

    function automatic logic [W-1:0] exp_rd();
        if (rd_pin_en) return m_s2;
        if (rd_out_en) return m_out;
        if (rd_dir_en) return m_dir;
        return '0;
    endfunction

    task automatic check_ports();
        check("R2", pad_oe, m_dir);
        check("R3", pad_out, m_out);
        check("R4", pad_pu, exp_pu());
        check(sleep_en ? "R9" : (rd_pin_en ? "R8" : "R7"), rd_data, exp_rd());
    endtask

    task automatic idle_bus();
        wr_dir_en = 0; wr_out_en = 0; wr_pin_en = 0;
        rd_dir_en = 0; rd_out_en = 0; rd_pin_en = 0;
    endtask

    // one rising edge: model update, then compare at the falling edge
    task automatic step();
        @(posedge clk);
        if (wr_out_en)      m_out = wr_data;
        else if (wr_pin_en) m_out = m_out ^ wr_data;
        if (wr_dir_en)      m_dir = wr_data;
        if (!sleep_en) begin
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
        @(negedge clk);
        check_ports();
    endtask

    logic         done = 1'b0;
    logic [W-1:0] held;

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: reset state before release
        check("R1", pad_oe, '0);
        check("R1", pad_pu, '0);
        rst_n = 1'b1;

        // R2 R3 R4: outputs and pull-ups
        wr_dir_en = 1; wr_data = 8'h0F; step();
        idle_bus(); wr_out_en = 1; wr_data = 8'h3C; step();
        check("R4", pad_pu, 8'h30);
        pu_disable = 1; #1; check("R4", pad_pu, 8'h00);
        pu_disable = 0;

        // R5: toggle on input and output pins
        idle_bus(); wr_pin_en = 1; wr_data = 8'h81; step();
        check("R5", pad_out, 8'hBD);
        idle_bus(); wr_pin_en = 1; wr_data = 8'h00; step();
        check("R5", pad_out, 8'hBD);

        // R6: direct load beats toggle
        idle_bus(); wr_out_en = 1; wr_pin_en = 1; wr_data = 8'h55; step();
        check("R6", pad_out, 8'h55);

        // R7: readback priority
        idle_bus(); rd_dir_en = 1; rd_out_en = 1; #1;
        check("R7", rd_data, 8'h55);
        rd_out_en = 0; #1; check("R7", rd_data, 8'h0F);

        // R8: latency of exactly two edges
        idle_bus(); rd_pin_en = 1; pad_in = 8'h00; step(); step();
        pad_in = 8'hA5; step();
        check("R8", rd_data, 8'h00);
        step();
        check("R8", rd_data, 8'hA5);

        // R9: freeze during sleep, resume after
        sleep_en = 1; pad_in = 8'h3C; step(); step(); step();
        check("R9", rd_data, 8'hA5);
        sleep_en = 0; step();
        check("R9", rd_data, 8'hA5);
        step();
        check("R9", rd_data, 8'h3C);

        // R1: reset acts between clock edges
        idle_bus(); wr_dir_en = 1; wr_out_en = 1; wr_data = 8'hF0; step();
        idle_bus();
        #3 rst_n = 1'b0; #2;
        check("R1", pad_oe, '0);
        check("R1", pad_pu, '0);
        check("R1", pad_out, '0);
        m_dir = '0; m_out = '0; m_s1 = '0; m_s2 = '0;
        @(negedge clk); rst_n = 1'b1;

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            wr_dir_en  = ($urandom % 4) == 0;
            wr_out_en  = ($urandom % 3) == 0;
            wr_pin_en  = ($urandom % 3) == 0;
            wr_data    = W'($urandom);
            rd_dir_en  = $urandom % 2;
            rd_out_en  = $urandom % 2;
            rd_pin_en  = $urandom % 2;
            pu_disable = ($urandom % 5) == 0;
            sleep_en   = ($urandom % 6) == 0;
            pad_in     = W'($urandom);
            step();
        end

        // R9: pads ignored while asleep, seen through the read port
        idle_bus(); rd_pin_en = 1; sleep_en = 1; #1; held = rd_data;
        for (int k = 0; k < 4; k++) begin
            pad_in = ~pad_in;
            step();
            check("R9", rd_data, held);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule